// File: doc/BRIEF.md
# Boot overlay access counter

This block holds a memory card in boot-overlay mode after power-on. While the overlay is active, the card's address decoder places boot ROM code at address 0000. The processor starts from its reset vector and reads a short stream from there: a one-byte no-operation (00) followed by a three-byte jump (C3, low byte, high byte). The block counts those card read accesses. After the fourth one it drops the overlay flag, so the jump lands on the ROM at its normal address under the regular memory map.

The card-read strobe comes from the decoder and is asynchronous to the block clock. It passes through a small synchronizer. An access is counted once, on the trailing (falling) edge of the synchronized strobe, however many clocks the read lasts. A board strap decides whether the overlay is used at all. With the strap clear, the phantom flag stays low and the card starts in normal mapping. Power-on clear restarts the whole sequence at any time. There is no data stream here: every pin is a plain control or status line, with no valid/ready handshake.

Top module: `boot_overlay_ctr`

## Requirements
- R1: When power-on clear is released with the strap set, `phantom_o` is 1 and stays 1 while no read access has completed.
- R2: With `strap_en` at 0, `phantom_o` is 0 at all times, whatever the state of the sequence.
- R3: A read access counts exactly once, on the falling edge of `rd_strobe`, however long the strobe was held high. The rising edge alone never releases the overlay, and the first three accesses leave `phantom_o` at 1.
- R4: `phantom_o` goes to 0 on the third rising clock edge after `rd_strobe` falls at the end of the fourth access. It is still 1 after the second edge.
- R5: After release the count saturates. Further read accesses leave `phantom_o` at 0 until the next power-on clear.
- R6: Asserting `por_clr` in the middle of a sequence discards the accesses already counted. A full four new accesses are needed before release.
- R7: Accesses are counted while `strap_en` is 0. Setting the strap after four accesses shows `phantom_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_clr | input | 1 | Power-on clear, active high, asynchronous; restarts the overlay |
| rd_strobe | input | 1 | Card read access strobe from the decoder, high during a read, asynchronous |
| strap_en | input | 1 | Overlay enable strap; 0 keeps the card in normal mapping |
| phantom_o | output | 1 | Overlay flag to the address decoder, 1 = boot overlay active |

## Verification
A wrong count or a wrong start latch shows at the ports only as a change in when `phantom_o` falls. An off-by-one releases the overlay one access early or late, that is, on the third or fifth trailing edge. A stuck latch either never releases or never arms after clear. The bench samples `phantom_o` on both sides of the exact third clock edge after each trailing edge, so a one-cycle shift in the synchronizer or edge path is visible in the same access. Reads held high for many cycles, reads after release, and a clear in mid-sequence expose counting on the wrong edge, counting past saturation, and a counter that clear does not reset.

// File: rtl/boot_overlay_pkg.sv
package boot_overlay_pkg;
  localparam int unsigned DEF_BOOT_READS  = 4;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/boot_rd_sync.sv
module boot_rd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic por_clr,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or posedge por_clr) begin
          if (por_clr) chain[0] <= 1'b0;
          else         chain[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or posedge por_clr) begin
          if (por_clr) chain[g] <= 1'b0;
          else         chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/boot_fall_det.sv
module boot_fall_det (
  input  logic clk,
  input  logic por_clr,
  input  logic level_i,
  output logic fall_o
);
  logic level_q;

  always_ff @(posedge clk or posedge por_clr) begin
    if (por_clr) level_q <= 1'b0;
    else         level_q <= level_i;
  end

  assign fall_o = level_q & ~level_i;
endmodule

// File: rtl/boot_seq.sv
module boot_seq #(
  parameter int unsigned BOOT_READS = 4,
  parameter int unsigned CNT_W      = 3
) (
  input  logic             clk,
  input  logic             por_clr,
  input  logic             step_i,
  output logic             overlay_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BOOT_READS - 1);

  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or posedge por_clr) begin
    if (por_clr) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (armed_q && step_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) armed_q <= 1'b0;
    end
  end

  assign overlay_o = armed_q;
  assign count_o   = cnt_q;
endmodule

// File: rtl/boot_overlay_ctr.sv
module boot_overlay_ctr
  import boot_overlay_pkg::*;
#(
  parameter int unsigned BOOT_READS  = DEF_BOOT_READS,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic por_clr,
  input  logic rd_strobe,
  input  logic strap_en,
  output logic phantom_o
);
  localparam int unsigned CNT_W = cnt_width(BOOT_READS);

  logic             rd_sync;
  logic             cnt_step;
  logic             overlay;
  logic [CNT_W-1:0] access_cnt;

  boot_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .por_clr (por_clr),
    .async_i (rd_strobe),
    .sync_o  (rd_sync)
  );

  boot_fall_det u_fall (
    .clk     (clk),
    .por_clr (por_clr),
    .level_i (rd_sync),
    .fall_o  (cnt_step)
  );

  boot_seq #(.BOOT_READS(BOOT_READS), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .por_clr   (por_clr),
    .step_i    (cnt_step),
    .overlay_o (overlay),
    .count_o   (access_cnt)
  );

  assign phantom_o = overlay & strap_en;
endmodule

// File: rtl/boot_overlay_chk.sv
module boot_overlay_chk #(
  parameter int unsigned BOOT_READS = 4,
  parameter int unsigned CNT_W      = 3
) (
  input logic             clk,
  input logic             por_clr,
  input logic             strap_en,
  input logic             phantom_o,
  input logic             step,
  input logic [CNT_W-1:0] count
);
  a_r1_armed_after_clear: assert property (@(posedge clk) disable iff (por_clr)
    ($past(por_clr) && strap_en) |-> phantom_o);

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (por_clr)
    step |=> !step);

  a_r3_count_step: assert property (@(posedge clk) disable iff (por_clr)
    (count != $past(count)) |-> ((count == $past(count) + 1'b1) && $past(step)));

  a_r4_release_on_edge: assert property (@(posedge clk) disable iff (por_clr)
    (strap_en && $past(strap_en) && $fell(phantom_o)) |-> $past(step));

  a_r5_stays_released: assert property (@(posedge clk) disable iff (por_clr)
    (strap_en && !phantom_o) |=> (!strap_en || !phantom_o));

  a_r5_saturate: assert property (@(posedge clk) disable iff (por_clr)
    count <= CNT_W'(BOOT_READS));
endmodule

bind boot_overlay_ctr boot_overlay_chk #(.BOOT_READS(BOOT_READS), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .por_clr   (por_clr),
  .strap_en  (strap_en),
  .phantom_o (phantom_o),
  .step      (cnt_step),
  .count     (access_cnt)
);

// File: tb/boot_overlay_ctr_bench.sv
module boot_overlay_ctr_bench;
  logic clk = 1'b0;
  logic por_clr = 1'b1;
  logic rd_strobe = 1'b0;
  logic strap_en = 1'b1;
  logic phantom_o;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  boot_overlay_ctr u_boot_overlay_ctr (
    .clk       (clk),
    .por_clr   (por_clr),
    .rd_strobe (rd_strobe),
    .strap_en  (strap_en),
    .phantom_o (phantom_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s phantom_o actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic clear();
    @(negedge clk); por_clr = 1'b1;
    repeat (2) @(negedge clk);
    por_clr = 1'b0;
    @(negedge clk);
  endtask

  // one read access; after the falling edge, wait 2 edges (still armed), then 1 more
  task automatic access(input int hold, input string req, input logic exp_mid, input logic exp_end);
    rd_strobe = 1'b1;
    repeat (hold) @(negedge clk);
    rd_strobe = 1'b0;
    repeat (2) @(negedge clk);
    check(req, phantom_o, exp_mid);
    @(negedge clk);
    check(req, phantom_o, exp_end);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset_state();
    strap_en = 1'b1;
    clear();
    check("R1", phantom_o, 1'b1);
    repeat (10) @(negedge clk);
    check("R1", phantom_o, 1'b1);
  endtask

  task automatic t_boot_stream();
    strap_en = 1'b1;
    clear();
    access(1, "R3", 1'b1, 1'b1);
    access(3, "R3", 1'b1, 1'b1);
    access(2, "R3", 1'b1, 1'b1);
    access(1, "R4", 1'b1, 1'b0);
  endtask

  task automatic t_long_read();
    strap_en = 1'b1;
    clear();
    for (int i = 0; i < 3; i++) access(5, "R3", 1'b1, 1'b1);
    rd_strobe = 1'b1;
    repeat (20) @(negedge clk);
    check("R3", phantom_o, 1'b1);
    rd_strobe = 1'b0;
    repeat (2) @(negedge clk);
    check("R4", phantom_o, 1'b1);
    @(negedge clk);
    check("R4", phantom_o, 1'b0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_saturate();
    strap_en = 1'b1;
    clear();
    for (int i = 0; i < 4; i++) access(1, "R5", 1'b1, i == 3 ? 1'b0 : 1'b1);
    for (int i = 0; i < 12; i++) access(2, "R5", 1'b0, 1'b0);
    clear();
    check("R5", phantom_o, 1'b1);
  endtask

  task automatic t_mid_clear();
    strap_en = 1'b1;
    clear();
    for (int i = 0; i < 3; i++) access(1, "R6", 1'b1, 1'b1);
    clear();
    check("R6", phantom_o, 1'b1);
    for (int i = 0; i < 3; i++) access(1, "R6", 1'b1, 1'b1);
    access(1, "R6", 1'b1, 1'b0);
  endtask

  task automatic t_strap_off();
    strap_en = 1'b0;
    clear();
    check("R2", phantom_o, 1'b0);
    for (int i = 0; i < 2; i++) access(1, "R2", 1'b0, 1'b0);
    strap_en = 1'b1;
    #1 check("R2", phantom_o, 1'b1);
    strap_en = 1'b0;
    for (int i = 0; i < 2; i++) access(1, "R7", 1'b0, 1'b0);
    strap_en = 1'b1;
    #1 check("R7", phantom_o, 1'b0);
    @(negedge clk);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        summary();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    t_boot_stream();
    t_long_read();
    t_saturate();
    t_mid_clear();
    t_strap_off();
    done = 1'b1;
    summary();
  end
endmodule